// File: doc/BRIEF.md
# DMA Channel Arming and Request Gate

This block is the control front end for a module of DMA channels (two by default) that share one internal trigger source. Each channel has a small configuration register: an arm flag, a guard flag that must be set in the same write for the arm flag to change, a two-bit pacing mode, an internal-source select and a stop-on-terminal-count enable. The block keeps each channel's arm state and decides, cycle by cycle, whether that channel presents a transfer request to the bus engine.

A channel is paced by its own external request pin, by the module-wide internal event, or not at all. The module-wide event is either a timer tick or a serial-port event, picked by one select register shared by every channel of the module. External pins are resynchronised before use. Internal events are single-cycle pulses that are held in a per-channel pending flag until the bus engine acknowledges the transfer. Illegal configurations are flagged and never produce requests.

Top module: `dma_arm_ctl`

## Requirements
- R1: While a channel's arm flag is 0, its `req_vld` is 0 whatever its pins and the internal events do.
- R2: A configuration write with `cfg_guard`=1 loads `cfg_arm` into the arm flag, visible on `armed` one cycle later. With `cfg_guard`=0 the arm flag is unchanged while mode, source select and stop enable are still loaded.
- R3: A guarded write with `cfg_arm`=0 disarms the channel in the following cycle.
- R4: A `tc` pulse on an armed channel whose stop enable is 1 clears its arm flag in the next cycle, and wins over a guarded arm write in the same cycle. With stop enable 0, `tc` has no effect.
- R5: Mode 2'b00 (free-running): an armed, legal channel holds `req_vld` high every cycle with no trigger.
- R6: Modes 2'b01 (source-paced) and 2'b10 (destination-paced) with external source: `req_vld` follows `ext_req` of that channel delayed by two clock edges, gated by the arm flag.
- R7: Mode 2'b11 is reserved: `cfg_err` is 1 and `req_vld` stays 0.
- R8: Internal source selected (`cfg_use_int`=1) with any mode other than 2'b01 raises `cfg_err` and gives no request; with mode 2'b01 `cfg_err` is 0.
- R9: One module-wide select picks the internal event: 0 (reset value) the timer pulse `tmr_evt`, 1 the serial pulse `ser_evt`; it is loaded from `src_sel` when `src_we`=1 and applies to all channels alike.
- R10: On an armed internal-source channel, a selected event sets the pending flag, so `req_vld` rises the cycle after the event and stays high until an `ack` clears it; an event in the same cycle as `ack` keeps it set.
- R11: Disarming clears the pending flag, so a channel re-armed later shows no request from an old event.
- R12: Synchronous active-high reset leaves every channel disarmed, mode 2'b00, external source, stop disabled, nothing pending, and the select at timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | NCH | Per-channel configuration write strobe |
| cfg_arm | input | 1 | Arm value written (applied only with guard) |
| cfg_guard | input | 1 | Guard that permits the arm flag to change |
| cfg_sync | input | 2 | Pacing mode: 00 free, 01 source, 10 destination, 11 reserved |
| cfg_use_int | input | 1 | 1 selects the module-wide internal event |
| cfg_tc_stop | input | 1 | 1 disarms on terminal count |
| src_we | input | 1 | Load strobe for the module-wide source select |
| src_sel | input | 1 | 0 timer event, 1 serial event |
| ext_req | input | NCH | Asynchronous external request pins |
| tmr_evt | input | 1 | Single-cycle timer event |
| ser_evt | input | 1 | Single-cycle serial-port event |
| ack | input | NCH | Bus engine accepted a transfer for the channel |
| tc | input | NCH | Terminal-count pulse from the counter logic |
| armed | output | NCH | Arm flag per channel |
| req_vld | output | NCH | Transfer request to the bus engine |
| cfg_err | output | NCH | Illegal configuration flag |

## Verification
The bench drives unguarded writes that change the mode while trying to flip the arm flag; a design that ignores the guard arms by accident, and one that drops the whole write misses the mode change visible on `cfg_err`. It fires terminal count together with a guarded arm write, where a wrong priority leaves the channel armed. It sends internal events while disarmed and right before a disarm, then re-arms: a design that keeps stale pending state raises a request with no new event. It also switches the module select between timer and serial events and overlaps an acknowledge with a new event, where a wrong ordering drops a request.

// File: rtl/dmaarm_pkg.sv
package dmaarm_pkg;

    typedef enum logic [1:0] {
        SYNC_FREE = 2'b00,
        SYNC_SRC  = 2'b01,
        SYNC_DST  = 2'b10,
        SYNC_RSVD = 2'b11
    } sync_e;

    typedef struct packed {
        logic  go;
        logic  guard;
        sync_e sync;
        logic  use_int;
        logic  tc_stop;
    } cfg_wr_t;

    localparam int SYNC_MIN_STAGES = 2;

    function automatic logic cfg_bad(input sync_e s, input logic ui);
        return (s == SYNC_RSVD) || (ui && (s != SYNC_SRC));
    endfunction

endpackage

// File: rtl/dmaarm_sync.sv
module dmaarm_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[LAST];
endmodule

// File: rtl/dmaarm_chan.sv
module dmaarm_chan
    import dmaarm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    we,
    input  cfg_wr_t wr,
    input  logic    ext_s,
    input  logic    int_evt,
    input  logic    ack,
    input  logic    tc,
    output logic    armed,
    output logic    req_vld,
    output logic    cfg_err
);
    logic  go_q, go_d;
    sync_e sync_q;
    logic  ui_q, stop_q, pend_q, pend_d;
    logic  tc_kill, trig;

    assign tc_kill = go_q & stop_q & tc;

    always_comb begin
        go_d = go_q;
        if (we && wr.guard) go_d = wr.go;
        if (tc_kill)        go_d = 1'b0;
    end

    always_comb begin
        if (!go_q || !ui_q) pend_d = 1'b0;
        else if (int_evt)   pend_d = 1'b1;
        else if (ack)       pend_d = 1'b0;
        else                pend_d = pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            go_q   <= 1'b0;
            sync_q <= SYNC_FREE;
            ui_q   <= 1'b0;
            stop_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            go_q   <= go_d;
            pend_q <= pend_d;
            if (we) begin
                sync_q <= wr.sync;
                ui_q   <= wr.use_int;
                stop_q <= wr.tc_stop;
            end
        end
    end

    always_comb begin
        if (sync_q == SYNC_FREE) trig = 1'b1;
        else if (ui_q)           trig = pend_q;
        else                     trig = ext_s;
    end

    assign cfg_err = cfg_bad(sync_q, ui_q);
    assign armed   = go_q;
    assign req_vld = go_q & ~cfg_err & trig;

    a_r1_silent_disarmed: assert property (@(posedge clk) disable iff (rst)
        !go_q |-> !req_vld);
    a_r2_guard_holds_arm: assert property (@(posedge clk) disable iff (rst)
        (we && !wr.guard && !tc) |=> $stable(go_q));
    a_r4_tc_disarms: assert property (@(posedge clk) disable iff (rst)
        (go_q && stop_q && tc) |=> !go_q);
    a_r7_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
        (sync_q == SYNC_RSVD) |-> (cfg_err && !req_vld));
    a_r10_ack_drops: assert property (@(posedge clk) disable iff (rst)
        (req_vld && ui_q && sync_q == SYNC_SRC && ack && !int_evt && !we && !tc)
        |=> !req_vld);
    a_r11_disarm_flushes: assert property (@(posedge clk) disable iff (rst)
        !go_q |=> !pend_q);
endmodule

// File: rtl/dma_arm_ctl.sv
module dma_arm_ctl
    import dmaarm_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int SYNC_STAGES = SYNC_MIN_STAGES
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] cfg_we,
    input  logic           cfg_arm,
    input  logic           cfg_guard,
    input  logic [1:0]     cfg_sync,
    input  logic           cfg_use_int,
    input  logic           cfg_tc_stop,
    input  logic           src_we,
    input  logic           src_sel,
    input  logic [NCH-1:0] ext_req,
    input  logic           tmr_evt,
    input  logic           ser_evt,
    input  logic [NCH-1:0] ack,
    input  logic [NCH-1:0] tc,
    output logic [NCH-1:0] armed,
    output logic [NCH-1:0] req_vld,
    output logic [NCH-1:0] cfg_err
);
    logic           sel_q;
    logic           mod_evt;
    logic [NCH-1:0] ext_s;
    cfg_wr_t        wr;

    assign wr = '{go: cfg_arm, guard: cfg_guard, sync: sync_e'(cfg_sync),
                  use_int: cfg_use_int, tc_stop: cfg_tc_stop};

    always_ff @(posedge clk) begin
        if (rst)         sel_q <= 1'b0;
        else if (src_we) sel_q <= src_sel;
    end

    assign mod_evt = sel_q ? ser_evt : tmr_evt;

    dmaarm_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ext_req),
        .q   (ext_s)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dmaarm_chan u_ch (
            .clk     (clk),
            .rst     (rst),
            .we      (cfg_we[c]),
            .wr      (wr),
            .ext_s   (ext_s[c]),
            .int_evt (mod_evt),
            .ack     (ack[c]),
            .tc      (tc[c]),
            .armed   (armed[c]),
            .req_vld (req_vld[c]),
            .cfg_err (cfg_err[c])
        );
    end

    a_r9_sel_hold: assert property (@(posedge clk) disable iff (rst)
        !src_we |=> $stable(sel_q));
    a_r9_sel_load: assert property (@(posedge clk) disable iff (rst)
        src_we |=> (sel_q == $past(src_sel)));
endmodule

// File: tb/dma_arm_ctl_bench.sv
`timescale 1ns/1ps
module dma_arm_ctl_bench;
    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] cfg_we = '0;
    logic           cfg_arm = 1'b0, cfg_guard = 1'b0, cfg_use_int = 1'b0, cfg_tc_stop = 1'b0;
    logic [1:0]     cfg_sync = 2'b00;
    logic           src_we = 1'b0, src_sel = 1'b0;
    logic [NCH-1:0] ext_req = '0, ack = '0, tc = '0;
    logic           tmr_evt = 1'b0, ser_evt = 1'b0;
    logic [NCH-1:0] armed, req_vld, cfg_err;

    always #2.5 clk = ~clk;

    dma_arm_ctl #(.NCH(NCH)) u_dma_arm_ctl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_arm(cfg_arm), .cfg_guard(cfg_guard),
        .cfg_sync(cfg_sync), .cfg_use_int(cfg_use_int), .cfg_tc_stop(cfg_tc_stop),
        .src_we(src_we), .src_sel(src_sel), .ext_req(ext_req), .tmr_evt(tmr_evt),
        .ser_evt(ser_evt), .ack(ack), .tc(tc), .armed(armed), .req_vld(req_vld),
        .cfg_err(cfg_err)
    );

    // behavioural reference state
    int    m_go[NCH], m_mode[NCH], m_int[NCH], m_stop[NCH], m_pend[NCH];
    int    m_p1[NCH], m_p2[NCH];
    int    m_sel;
    bit    started = 0;
    int    n_vec = 0, n_bad = 0, cycles = 0;
    string phase = "R12";

    always @(posedge clk) begin
        started = 1;
        cycles++;
        for (int c = 0; c < NCH; c++) begin
            if (rst) begin
                m_go[c] = 0; m_mode[c] = 0; m_int[c] = 0; m_stop[c] = 0;
                m_pend[c] = 0; m_p1[c] = 0; m_p2[c] = 0;
            end else begin
                int ev, nxt_go, nxt_pend;
                ev = (m_sel == 1) ? int'(ser_evt) : int'(tmr_evt);
                nxt_go = m_go[c];
                if (cfg_we[c] && cfg_guard) nxt_go = int'(cfg_arm);
                if (m_go[c] == 1 && m_stop[c] == 1 && tc[c]) nxt_go = 0;
                if (m_go[c] == 0 || m_int[c] == 0) nxt_pend = 0;
                else if (ev == 1) nxt_pend = 1;
                else if (ack[c]) nxt_pend = 0;
                else nxt_pend = m_pend[c];
                m_go[c] = nxt_go;
                m_pend[c] = nxt_pend;
                if (cfg_we[c]) begin
                    m_mode[c] = int'(cfg_sync);
                    m_int[c]  = int'(cfg_use_int);
                    m_stop[c] = int'(cfg_tc_stop);
                end
                m_p2[c] = m_p1[c];
                m_p1[c] = int'(ext_req[c]);
            end
        end
        if (rst) m_sel = 0;
        else if (src_we) m_sel = int'(src_sel);
    end

    function automatic bit exp_err(int c);
        return (m_mode[c] == 3) || (m_int[c] == 1 && m_mode[c] != 1);
    endfunction

    function automatic bit exp_req(int c);
        bit t;
        if (m_mode[c] == 0) t = 1;
        else if (m_int[c] == 1) t = (m_pend[c] == 1);
        else t = (m_p2[c] == 1);
        return (m_go[c] == 1) && !exp_err(c) && t;
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    always @(negedge clk) begin
        if (started) begin
            for (int c = 0; c < NCH; c++) begin
                n_vec++;
                if (armed[c] !== (m_go[c] == 1) || req_vld[c] !== exp_req(c) ||
                    cfg_err[c] !== exp_err(c)) begin
                    n_bad++;
                    $display("FAIL %s ch%0d: armed/req/err = %b%b%b expected %b%b%b",
                             phase, c, armed[c], req_vld[c], cfg_err[c],
                             m_go[c] == 1, exp_req(c), exp_err(c));
                end
            end
        end
        if (cycles > 20000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int c, bit arm, bit guard, bit [1:0] mode, bit ui, bit stop);
        cfg_we = '0; cfg_we[c] = 1'b1;
        cfg_arm = arm; cfg_guard = guard; cfg_sync = mode; cfg_use_int = ui; cfg_tc_stop = stop;
        tick(1);
        cfg_we = '0; cfg_guard = 1'b0;
    endtask

    task automatic pulse_tmr(); tmr_evt = 1'b1; tick(1); tmr_evt = 1'b0; endtask
    task automatic pulse_ser(); ser_evt = 1'b1; tick(1); ser_evt = 1'b0; endtask

    initial begin
        tick(3);
        rst = 1'b0;
        phase = "R12"; tick(3);

        // R1: triggers while disarmed
        phase = "R1";
        ext_req = '1; pulse_tmr(); pulse_ser(); tick(4); ext_req = '0; tick(3);

        // R2: unguarded write changes mode but not the arm flag
        phase = "R2";
        wr(0, 1, 0, 2'b11, 0, 0); tick(2);
        wr(0, 1, 0, 2'b00, 0, 0); tick(2);
        wr(0, 1, 1, 2'b00, 0, 0); tick(1);
        // R5: free-running request
        phase = "R5"; tick(4);
        // R3: guarded disarm
        phase = "R3"; wr(0, 0, 1, 2'b00, 0, 0); tick(3);

        // R6: external pacing through resynchroniser
        phase = "R6";
        wr(1, 1, 1, 2'b01, 0, 0);
        ext_req[1] = 1'b1; tick(3); ext_req[1] = 1'b0; tick(1);
        ext_req[1] = 1'b1; tick(1); ext_req[1] = 1'b0; tick(4);
        wr(1, 1, 0, 2'b10, 0, 0);
        ext_req[1] = 1'b1; tick(4); ext_req[1] = 1'b0; tick(3);

        // R4: terminal count
        phase = "R4";
        wr(1, 0, 0, 2'b01, 0, 1);
        tc[1] = 1'b1; tick(1); tc[1] = 1'b0; tick(2);
        wr(0, 1, 1, 2'b00, 0, 0);
        tc[0] = 1'b1; tick(1); tc[0] = 1'b0; tick(2);
        wr(0, 1, 0, 2'b00, 0, 1);
        cfg_we = 2'b01; cfg_arm = 1'b1; cfg_guard = 1'b1; cfg_sync = 2'b00;
        cfg_use_int = 1'b0; cfg_tc_stop = 1'b1; tc[0] = 1'b1;
        tick(1); cfg_we = '0; cfg_guard = 1'b0; tc[0] = 1'b0; tick(3);

        // R7: reserved mode
        phase = "R7";
        wr(0, 1, 1, 2'b11, 0, 0); ext_req = '1; tick(4); ext_req = '0;

        // R8: internal source with wrong mode
        phase = "R8";
        wr(0, 1, 1, 2'b00, 1, 0); pulse_tmr(); tick(2);
        wr(0, 1, 1, 2'b10, 1, 0); pulse_tmr(); tick(2);

        // R9 / R10: module source select and pending flag
        phase = "R10";
        wr(0, 1, 1, 2'b01, 1, 0);
        wr(1, 1, 1, 2'b01, 1, 0);
        tick(2); pulse_tmr(); tick(3);
        ack[0] = 1'b1; tick(1); ack[0] = 1'b0; tick(2);
        ack[1] = 1'b1; tmr_evt = 1'b1; tick(1); ack[1] = 1'b0; tmr_evt = 1'b0; tick(2);
        ack = '1; tick(1); ack = '0; tick(1);
        phase = "R9";
        pulse_ser(); tick(2);
        src_we = 1'b1; src_sel = 1'b1; tick(1); src_we = 1'b0; src_sel = 1'b0;
        pulse_tmr(); tick(2); pulse_ser(); tick(3);
        ack = '1; tick(1); ack = '0; tick(1);
        src_sel = 1'b1; tick(2); src_sel = 1'b0; pulse_ser(); tick(2);

        // R11: disarm flushes pending, re-arm shows nothing
        phase = "R11";
        wr(1, 0, 1, 2'b01, 1, 0);
        pulse_ser(); tick(1);
        wr(1, 1, 1, 2'b01, 1, 0); tick(4);
        pulse_ser(); tick(3);

        finish_run();
    end
endmodule